// File: doc/BRIEF.md
# Power-Fail Store and Recall Sequencer

This block sequences a memory in which every SRAM word has a nonvolatile shadow copy. It watches two digitized supply flags: one says the supply has sagged below the switch level, the other says it has gone below the lower reset level. It also watches the host's chip-enable and write-enable strobes. From these it decides when to copy the SRAM into the shadow cells and when to copy the shadow cells back. It drives a one-cycle store request and a one-cycle recall request to the array. A busy flag locks the host out while the supply is down or a transfer runs. A standby flag tells the power logic when the array may drop to low current.

When the supply sags, the host first gets a short grace window to finish the access it has in flight. A store then runs only if some write has completed since the last store or recall. When the supply returns, a recall runs only if the supply fell all the way below the reset level. A shallow brown-out leaves the SRAM contents in place. The store, recall and grace durations are counted in clock cycles. Leaving reset counts as a full power-on, so a recall follows as soon as the supply is good.

Top module: `nvsh_pfail_ctrl`

## Requirements
- R1: While reset is held, busy_o is 1 and both request outputs are 0. After release with the supply good, exactly one recall of RECALL_CYC busy cycles follows, then busy_o returns to 0.
- R2: After the below-switch flag rises in normal operation, busy_o stays 0 during a grace window. The window ends when chip enable is seen high, or after DELAY_CYC cycles. So store_req_o rises 2 cycles after the flag if chip enable is high, and DELAY_CYC+1 cycles after it if chip enable stays low.
- R3: A store is issued only if the dirty state is set when the grace window ends. Dirty is set when a write strobe ends: chip enable low and write enable low, then either one goes high, with busy_o low. A write that ends inside the grace window counts.
- R4: A store keeps busy_o at 1 for exactly STORE_CYC cycles, starting with the cycle in which store_req_o is 1. store_req_o lasts one cycle.
- R5: On supply return, a recall is issued only if the below-reset flag was seen since normal operation was left. A brown-out that stays above the reset level gives no recall.
- R6: A recall starts in the cycle after the below-switch flag is seen low. recall_req_o lasts one cycle, and busy_o stays 1 for exactly RECALL_CYC cycles before normal operation resumes.
- R7: If the supply recovers while a store runs, the store still lasts its full STORE_CYC cycles. Any recall then starts STORE_CYC cycles after store_req_o.
- R8: stby_ok_o is 1 only when chip enable is high and no store or recall is running. Supply-down waiting with no transfer allows standby.
- R9: Completing a store or a recall clears dirty. A later supply drop with no new write issues no store.
- R10: A write strobe made while busy_o is 1 is ignored and does not set dirty.
- R11: store_req_o and recall_req_o are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sup_below_sw_i | input | 1 | Supply is below the switch threshold |
| sup_below_rst_i | input | 1 | Supply is below the reset threshold (implies below switch) |
| ce_ni | input | 1 | Host chip enable, active low |
| we_ni | input | 1 | Host write enable, active low |
| store_req_o | output | 1 | One-cycle pulse that starts an SRAM-to-shadow copy |
| recall_req_o | output | 1 | One-cycle pulse that starts a shadow-to-SRAM copy |
| busy_o | output | 1 | Host access is blocked |
| stby_ok_o | output | 1 | Array may enter standby |

## Verification
The bench builds the block with DELAY_CYC=4, STORE_CYC=12 and RECALL_CYC=7. With these values every phase fits in a few dozen cycles, so each phase length and request position can be checked against exact cycle numbers. The bench sweeps all eight combinations of three conditions: a write before the sag or not, a dip below the reset level or not, and recovery during the store or after it. Directed cases cover a host holding chip enable through the grace window, a write that ends inside the window, writes made while busy, and the standby flag in each phase.

// File: rtl/nvsh_pkg.sv
package nvsh_pkg;
  typedef enum logic [2:0] {
    PH_RUN    = 3'd0,
    PH_GRACE  = 3'd1,
    PH_STORE  = 3'd2,
    PH_DOWN   = 3'd3,
    PH_RECALL = 3'd4
  } phase_e;
endpackage

// File: rtl/nvsh_rst_sync.sv
module nvsh_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [SYNC_STAGES-1:0] sh_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sh_q <= '0;
        else          sh_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge arst_ni) begin
        if (!arst_ni) sh_q <= '0;
        else          sh_q <= {sh_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_no = sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/nvsh_phase_timer.sv
module nvsh_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)              cnt_d = load_val_i;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R4 / R6: an expired timer stays expired until reloaded
  p_hold_at_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);
  // R6: a running timer moves down by exactly one per cycle
  p_step_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !zero_o) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/nvsh_dirty_track.sv
module nvsh_dirty_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_ni,
  input  logic we_ni,
  input  logic accept_i,
  input  logic clear_i,
  output logic dirty_o
);
  logic wr_act_q, wr_act_d;
  logic dirty_q, dirty_d;
  logic wr_done;

  assign wr_act_d = accept_i & ~ce_ni & ~we_ni;
  assign wr_done  = wr_act_q & (ce_ni | we_ni);

  always_comb begin
    dirty_d = dirty_q;
    if (clear_i)      dirty_d = 1'b0;
    else if (wr_done) dirty_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      dirty_q  <= 1'b0;
    end else begin
      wr_act_q <= wr_act_d;
      dirty_q  <= dirty_d;
    end
  end

  // a strobe finishing this cycle already counts for the decision
  assign dirty_o = dirty_q | wr_done;

  // R10: with access blocked and no strobe pending, dirty cannot appear
  p_blocked_write_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!accept_i && !wr_act_q && !dirty_q) |=> !dirty_q);
  // R9: completion of a transfer leaves the word set clean
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !dirty_q);
endmodule

// File: rtl/nvsh_pfail_ctrl.sv
module nvsh_pfail_ctrl
  import nvsh_pkg::*;
#(
  parameter int DELAY_CYC  = 50,
  parameter int STORE_CYC  = 500000,
  parameter int RECALL_CYC = 27500
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sup_below_sw_i,
  input  logic sup_below_rst_i,
  input  logic ce_ni,
  input  logic we_ni,
  output logic store_req_o,
  output logic recall_req_o,
  output logic busy_o,
  output logic stby_ok_o
);
  localparam int MAX_A   = (DELAY_CYC > STORE_CYC) ? DELAY_CYC : STORE_CYC;
  localparam int MAX_CYC = (MAX_A > RECALL_CYC) ? MAX_A : RECALL_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);
  localparam logic [TW-1:0] LD_DELAY  = TW'(DELAY_CYC - 1);
  localparam logic [TW-1:0] LD_STORE  = TW'(STORE_CYC - 1);
  localparam logic [TW-1:0] LD_RECALL = TW'(RECALL_CYC - 1);

  logic          rst_q_n;
  phase_e        cur_q, nxt;
  logic          dip_q, dip_d;
  logic          st_req_q, rc_req_q;
  logic          st_go, rc_go, nv_done;
  logic          tload, tzero;
  logic [TW-1:0] tval;
  logic          dirty_eff;
  logic          accept;

  nvsh_rst_sync #(.SYNC_STAGES(2)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_q_n)
  );

  nvsh_phase_timer #(.W(TW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_q_n),
    .load_i     (tload),
    .load_val_i (tval),
    .zero_o     (tzero)
  );

  nvsh_dirty_track u_dirty (
    .clk_i    (clk_i),
    .rst_ni   (rst_q_n),
    .ce_ni    (ce_ni),
    .we_ni    (we_ni),
    .accept_i (accept),
    .clear_i  (nv_done),
    .dirty_o  (dirty_eff)
  );

  // next phase
  always_comb begin
    nxt     = cur_q;
    tload   = 1'b0;
    tval    = '0;
    st_go   = 1'b0;
    rc_go   = 1'b0;
    nv_done = 1'b0;
    unique case (cur_q)
      PH_RUN: begin
        if (sup_below_sw_i) begin
          nxt   = PH_GRACE;
          tload = 1'b1;
          tval  = LD_DELAY;
        end
      end
      PH_GRACE: begin
        if (ce_ni || tzero) begin
          if (dirty_eff) begin
            nxt   = PH_STORE;
            tload = 1'b1;
            tval  = LD_STORE;
            st_go = 1'b1;
          end else begin
            nxt = PH_DOWN;
          end
        end
      end
      PH_STORE: begin
        if (tzero) begin
          nv_done = 1'b1;
          if (sup_below_sw_i) begin
            nxt = PH_DOWN;
          end else if (dip_q) begin
            nxt   = PH_RECALL;
            tload = 1'b1;
            tval  = LD_RECALL;
            rc_go = 1'b1;
          end else begin
            nxt = PH_RUN;
          end
        end
      end
      PH_DOWN: begin
        if (!sup_below_sw_i) begin
          if (dip_q) begin
            nxt   = PH_RECALL;
            tload = 1'b1;
            tval  = LD_RECALL;
            rc_go = 1'b1;
          end else begin
            nxt = PH_RUN;
          end
        end
      end
      PH_RECALL: begin
        if (tzero) begin
          nv_done = 1'b1;
          nxt     = PH_RUN;
        end
      end
      default: nxt = PH_DOWN;
    endcase
  end

  // reset-level crossing latch
  always_comb begin
    dip_d = dip_q;
    if (cur_q == PH_RUN && !sup_below_sw_i) dip_d = 1'b0;
    else if (sup_below_rst_i)               dip_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cur_q    <= PH_DOWN;
      dip_q    <= 1'b1;
      st_req_q <= 1'b0;
      rc_req_q <= 1'b0;
    end else begin
      cur_q    <= nxt;
      dip_q    <= dip_d;
      st_req_q <= st_go;
      rc_req_q <= rc_go;
    end
  end

  assign busy_o       = (cur_q == PH_STORE) || (cur_q == PH_DOWN) || (cur_q == PH_RECALL);
  assign accept       = ~busy_o;
  assign store_req_o  = st_req_q;
  assign recall_req_o = rc_req_q;
  assign stby_ok_o    = ce_ni & ~((cur_q == PH_STORE) || (cur_q == PH_RECALL));

  p_req_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    !(store_req_o && recall_req_o));
  p_store_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    store_req_o |=> !store_req_o);
  p_store_blocks_r4: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    store_req_o |-> busy_o);
  p_store_dirty_r3: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    store_req_o |-> $past(dirty_eff));
  p_recall_dip_r5: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    recall_req_o |-> $past(dip_q));
  p_recall_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    recall_req_o |=> !recall_req_o);
  p_busy_release_r6: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    $fell(busy_o) |-> $past(tzero || cur_q == PH_DOWN));
endmodule

// File: tb/tb_nvsh_pfail_ctrl.sv
module tb_nvsh_pfail_ctrl;
  localparam int DLY = 4;
  localparam int STC = 12;
  localparam int RCC = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic below_sw, below_rst, ce_n, we_n;
  logic store_req, recall_req, busy, stby_ok;

  int n_chk = 0;
  int n_fail = 0;

  int cyc = 0;
  int st_cnt, rc_cnt, st_at, rc_at, len, last_len;
  logic prev_busy = 1'b1;

  always #10 clk = ~clk;

  nvsh_pfail_ctrl #(.DELAY_CYC(DLY), .STORE_CYC(STC), .RECALL_CYC(RCC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .sup_below_sw_i(below_sw), .sup_below_rst_i(below_rst),
    .ce_ni(ce_n), .we_ni(we_n), .store_req_o(store_req), .recall_req_o(recall_req),
    .busy_o(busy), .stby_ok_o(stby_ok)
  );

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (store_req)  begin st_cnt = st_cnt + 1; st_at = cyc; len = 0; end
    if (recall_req) begin rc_cnt = rc_cnt + 1; rc_at = cyc; len = 0; end
    if (busy) len = len + 1;
    else if (prev_busy) last_len = len;
    prev_busy = busy;
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic clr_mon();
    st_cnt = 0; rc_cnt = 0; st_at = -1; rc_at = -1; len = 0; last_len = -1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (act != exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_write();
    ce_n = 1'b0; we_n = 1'b0; tick(2);
    we_n = 1'b1; ce_n = 1'b1; tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail = n_fail + 1;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int dc, rel;
    rst_n = 1'b0; below_sw = 1'b0; below_rst = 1'b0; ce_n = 1'b1; we_n = 1'b1;
    clr_mon();
    tick(3);
    // R1 reset state
    chk("R1 busy in reset", int'(busy), 1);
    chk("R1 store_req in reset", int'(store_req), 0);
    chk("R1 recall_req in reset", int'(recall_req), 0);
    clr_mon();
    rst_n = 1'b1;
    tick(20);
    chk("R1 power-on recall count", rc_cnt, 1);
    chk("R1 power-on recall length", last_len, RCC);
    chk("R1 idle after recall", int'(busy), 0);

    // R8 standby in normal operation
    ce_n = 1'b1; #1;
    chk("R8 stby idle deselected", int'(stby_ok), 1);
    ce_n = 1'b0; #1;
    chk("R8 stby idle selected", int'(stby_ok), 0);
    ce_n = 1'b1; tick(1);

    // sweep: write / dip / recovery during store (R3 R5 R6 R7)
    for (int d = 0; d < 2; d++) begin
      for (int p = 0; p < 2; p++) begin
        for (int r = 0; r < 2; r++) begin
          tick(1);
          if (d == 1) do_write();
          clr_mon();
          dc = cyc;
          below_sw = 1'b1;
          if (p == 1) begin
            tick(2); below_rst = 1'b1; tick(2); below_rst = 1'b0; tick(2);
          end else begin
            tick(6);
          end
          if (r == 0) tick(25);
          rel = cyc;
          below_sw = 1'b0;
          tick(40);
          chk("R3 store iff dirty", st_cnt, d);
          chk("R5 recall iff dip", rc_cnt, p);
          chk("R11 idle at end", int'(busy), 0);
          if (d == 1) chk("R2 store start ce high", st_at, dc + 2);
          if (p == 1) chk("R6 recall length", last_len, RCC);
          if (d == 1 && r == 1 && p == 1) chk("R7 recall after full store", rc_at, st_at + STC);
          else if (p == 1) chk("R6 recall start", rc_at, rel + 1);
          if (d == 1 && r == 1 && p == 0) chk("R4 store length", last_len, STC);
        end
      end
    end

    // R9: nothing written since the last recall -> no store
    tick(1); clr_mon();
    below_sw = 1'b1; tick(10); below_sw = 1'b0; tick(5);
    chk("R9 clean after transfer", st_cnt, 0);

    // R2: host holds chip enable through the whole grace window
    do_write();
    ce_n = 1'b0; we_n = 1'b1;
    clr_mon(); dc = cyc; below_sw = 1'b1;
    tick(2);
    chk("R2 no busy in grace", int'(busy), 0);
    tick(20); ce_n = 1'b1;
    chk("R2 store start after timeout", st_at, dc + DLY + 1);
    below_sw = 1'b0; tick(20);

    // R3: a write that ends inside the grace window is stored
    ce_n = 1'b0; we_n = 1'b0; tick(1);
    clr_mon(); dc = cyc; below_sw = 1'b1;
    tick(2); we_n = 1'b1; ce_n = 1'b1;
    tick(5);
    chk("R3 in-flight write stored", st_cnt, 1);
    chk("R3 in-flight store start", st_at, dc + 3);
    below_sw = 1'b0; tick(20);

    // R8: standby during store and during supply-down wait
    do_write();
    clr_mon(); below_sw = 1'b1; tick(4);
    chk("R8 busy during store", int'(busy), 1);
    chk("R8 no stby during store", int'(stby_ok), 0);
    tick(20);
    chk("R8 stby while down", int'(stby_ok), 1);
    below_sw = 1'b0; tick(5);

    // R10: writes while busy are ignored
    clr_mon(); below_sw = 1'b1; tick(4);
    do_write();
    below_sw = 1'b0; tick(5);
    chk("R10 down wait leaves busy 0 after", int'(busy), 0);
    clr_mon(); below_sw = 1'b1; tick(10);
    chk("R10 blocked write not stored", st_cnt, 0);
    below_sw = 1'b0; tick(5);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule